// File: doc/BRIEF.md
# Flash Flag Status Register

This block holds the eight-bit flag register that a serial flash controller reports to its host. The surrounding controller feeds it single-cycle event pulses. These pulses say that an internal program or erase operation has started or finished, that a suspend or resume command was accepted, that a failure was detected, or that the host asked for the error flags to be cleared. The block turns these pulses into a register value that the read path can shift out at any time.

Error flags latch on the first failure and stay set across later operations. Only the dedicated clear command resets them. That command needs no prior write-enable step, so the block has no enable input for it. A suspend flag rises as soon as the suspend command is accepted, even if the operation might still complete before it actually pauses. A resume or the end of the operation drops the suspend flag again.

Top module: `flash_flag_status`

## Requirements
- R1: While reset is active and in the first cycle after it, `flags_o` reads 8'h80: ready set, all other bits zero.
- R2: Bit 7 (ready) reads 0 in the cycle after an `op_start_i` pulse and 1 in the cycle after an `op_done_i` pulse. When both pulse in the same cycle, start wins and bit 7 reads 0.
- R3: A failure pulse sets its error bit in the following cycle. `erase_fail_i` sets bit 5 for any erase size. `prog_fail_i` sets bit 4, `vpp_fail_i` sets bit 3 and `prot_fail_i` sets bit 1.
- R4: A set error bit stays 1 through start, done, suspend and resume pulses until a clear command.
- R5: A `clr_flags_i` pulse zeroes bits 5, 4, 3 and 1 in the following cycle. It leaves bits 7, 6 and 2 unchanged, and no enable input is needed.
- R6: If a failure pulse and `clr_flags_i` arrive in the same cycle, the failure's error bit reads 1 afterwards.
- R7: `susp_erase_i` sets bit 6 and `susp_prog_i` sets bit 2 in the following cycle, whether or not an operation is still running.
- R8: A `resume_i` or `op_done_i` pulse clears bits 6 and 2 in the following cycle. A suspend pulse in the same cycle keeps its own bit set.
- R9: Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start_i | input | 1 | Internal program/erase operation begins |
| op_done_i | input | 1 | Internal operation finished |
| erase_fail_i | input | 1 | Erase failure detected |
| prog_fail_i | input | 1 | Program failure detected |
| vpp_fail_i | input | 1 | High-voltage supply fault detected |
| prot_fail_i | input | 1 | Operation targeted a protected area |
| susp_erase_i | input | 1 | Suspend accepted during an erase |
| susp_prog_i | input | 1 | Suspend accepted during a program |
| resume_i | input | 1 | Resume command accepted |
| clr_flags_i | input | 1 | Clear-error-flags command |
| flags_o | output | 8 | Flag register value |

## Verification
The assertions assume every event input is a clean single-cycle pulse sampled on the clock. They also take no position on whether the events arrive in a sensible protocol order. This is why they only check the set-wins priorities and never, for example, that a suspend happens during a busy phase. To stay within these assumptions, the stimulus drives inputs only on the falling edge. Beyond the directed cases, it deliberately sends random, protocol-illegal mixes of pulses. The bench model applies the same priorities regardless of order.

// File: rtl/flash_flag_status.sv
module flash_flag_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start_i,
  input  logic       op_done_i,
  input  logic       erase_fail_i,
  input  logic       prog_fail_i,
  input  logic       vpp_fail_i,
  input  logic       prot_fail_i,
  input  logic       susp_erase_i,
  input  logic       susp_prog_i,
  input  logic       resume_i,
  input  logic       clr_flags_i,
  output logic [7:0] flags_o
);

  localparam int NERR = 4;

  logic            rdy_q;
  logic            esus_q;
  logic            psus_q;
  logic [NERR-1:0] err_q;   // {erase, program, vpp, protection}
  logic [NERR-1:0] err_set;
  logic            susp_clr;

  assign err_set  = {erase_fail_i, prog_fail_i, vpp_fail_i, prot_fail_i};
  assign susp_clr = resume_i | op_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      esus_q <= 1'b0;
      psus_q <= 1'b0;
    end else begin
      if (op_start_i)     rdy_q <= 1'b0;
      else if (op_done_i) rdy_q <= 1'b1;
      if (susp_erase_i)   esus_q <= 1'b1;
      else if (susp_clr)  esus_q <= 1'b0;
      if (susp_prog_i)    psus_q <= 1'b1;
      else if (susp_clr)  psus_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NERR; g++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n)             err_q[g] <= 1'b0;
      else if (err_set[g])    err_q[g] <= 1'b1;
      else if (clr_flags_i)   err_q[g] <= 1'b0;
    end
  end

  assign flags_o = {rdy_q, esus_q, err_q[3], err_q[2], err_q[1], psus_q, err_q[0], 1'b0};

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_i |=> !flags_o[7]);
  p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done_i && !op_start_i) |=> flags_o[7]);
  p_erase_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fail_i |=> flags_o[5]);
  p_prot_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fail_i |=> flags_o[1]);
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags_i |=> ((flags_o[5:3] & $past(flags_o[5:3])) == $past(flags_o[5:3])));
  p_clear_errs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags_i && !erase_fail_i && !prog_fail_i) |=> !flags_o[5] && !flags_o[4]);
  p_clear_keeps_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags_i && !susp_clr && !susp_erase_i && !susp_prog_i) |=> $stable(flags_o[6]) && $stable(flags_o[2]));
  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags_i && vpp_fail_i) |=> flags_o[3]);
  p_susp_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_prog_i |=> flags_o[2]);
  p_susp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_clr && !susp_erase_i) |=> !flags_o[6]);

endmodule

// File: tb/flash_flag_status_tb_top.sv
`timescale 1ns/1ps
module flash_flag_status_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] stim = '0;  // {start,done,efail,pfail,vfail,xfail,se,sp,resume,clr}
  logic [7:0] flags;
  logic [7:0] exp_flags = 8'h80;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  flash_flag_status dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_start_i(stim[9]), .op_done_i(stim[8]),
    .erase_fail_i(stim[7]), .prog_fail_i(stim[6]),
    .vpp_fail_i(stim[5]), .prot_fail_i(stim[4]),
    .susp_erase_i(stim[3]), .susp_prog_i(stim[2]),
    .resume_i(stim[1]), .clr_flags_i(stim[0]),
    .flags_o(flags)
  );

  // behavioural reference, priorities taken from the requirements
  always @(posedge clk) begin
    logic [7:0] n;
    if (!rst_n) exp_flags = 8'h80;
    else begin
      n = exp_flags;
      if (stim[9]) n[7] = 1'b0; else if (stim[8]) n[7] = 1'b1;
      if (stim[3]) n[6] = 1'b1; else if (stim[1] || stim[8]) n[6] = 1'b0;
      if (stim[2]) n[2] = 1'b1; else if (stim[1] || stim[8]) n[2] = 1'b0;
      if (stim[7]) n[5] = 1'b1; else if (stim[0]) n[5] = 1'b0;
      if (stim[6]) n[4] = 1'b1; else if (stim[0]) n[4] = 1'b0;
      if (stim[5]) n[3] = 1'b1; else if (stim[0]) n[3] = 1'b0;
      if (stim[4]) n[1] = 1'b1; else if (stim[0]) n[1] = 1'b0;
      n[0] = 1'b0;
      exp_flags = n;
    end
  end

  task automatic compare();
    checks++;
    if (flags !== exp_flags) begin
      fails++;
      $display("FAIL %s: flags actual %h expected %h", tag, flags, exp_flags);
    end
  endtask

  task automatic step(input logic [9:0] v);
    @(negedge clk);
    compare();
    stim = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: cycles actual %0d expected below 50000", cycles);
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();                         // R1 during reset
    rst_n = 1'b1;
    idle(2);                           // R1 after reset
    tag = "R2";  step(10'b10_0000_0000); idle(2); step(10'b01_0000_0000); idle(1);
                 step(10'b11_0000_0000); idle(1); step(10'b01_0000_0000); idle(1);
    tag = "R3";  step(10'b00_1000_0000); idle(1); step(10'b00_0100_0000); idle(1);
                 step(10'b00_0010_0000); idle(1); step(10'b00_0001_0000); idle(1);
    tag = "R4";  step(10'b10_0000_0000); step(10'b01_0000_0000); step(10'b00_0000_1110); idle(2);
    tag = "R7";  step(10'b10_0000_0000); step(10'b00_0000_1000); idle(1); step(10'b00_0000_0100); idle(1);
    tag = "R5";  step(10'b00_0000_0001); idle(2);
    tag = "R6";  step(10'b00_1000_0001); idle(1); step(10'b00_0011_0001); idle(1);
    tag = "R8";  step(10'b00_0000_0010); idle(1); step(10'b00_0000_1000); step(10'b01_0000_0000); idle(1);
                 step(10'b00_0000_0110); idle(1); step(10'b00_0000_0010); idle(1);
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      r = r & 10'($urandom);
      step(r);
    end
    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule